// File: doc/BRIEF.md
# Skin Pixel Colour Classifier

This block sits on a streaming camera path and marks each RGB pixel as skin or non-skin. Every accepted pixel is mapped into a luminance/chrominance space built only from adders, subtractors and a fixed shift. Luminance is the weighted sum of the three channels scaled down by four. The two chrominance terms are the red-minus-green and blue-minus-green differences. A pixel is called skin when both chrominance terms fall inside fixed open windows. No multipliers or lookup tables are needed.

Pixels arrive with a valid qualifier and two framing markers, one for the first pixel of a frame and one for the last pixel of a line. The block returns the same stream two clock cycles later. Each output pixel carries its luminance and the skin flag, and the markers stay aligned with the data. Downstream filtering, region labelling and tracking consume this stream; they are not part of this block.

Top module: `skin_classifier`

## Requirements
- R1: For each accepted pixel, y_o equals (R + 2·G + B) shifted right by 2, computed without overflow (all channels at 255 give 255, all at 0 give 0).
- R2: With U = R − G as a signed value, a pixel is skin only if 10 < U < 74 (U = 10 and U = 74 are rejected, U = 11 and U = 73 accepted when V is in range).
- R3: With V = B − G as a signed value, a pixel is skin only if V > −40 (V = −40 is rejected, V = −39 accepted when U is in range).
- R4: V must also be strictly below the parameter V_HI (default 11): V = 10 is accepted, V = 11 rejected.
- R5: Negative chroma differences compare as signed values over the full range −255..255; a pixel with green above red is never skin.
- R6: A pixel presented with valid_i high at clock edge n appears on the outputs after edge n+1 (two register stages), with valid_o, sof_o and eol_o delayed by the same amount; back-to-back pixels stream at one per cycle.
- R7: A cycle with valid_i low gives valid_o low two cycles later, and y_o and skin_o keep the values of the last valid pixel through such gaps.
- R8: While rst_ni is low, valid_o, sof_o, eol_o, skin_o and y_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel qualifier |
| sof_i | input | 1 | First pixel of a frame |
| eol_i | input | 1 | Last pixel of a line |
| r_i | input | PIX_W | Red channel, unsigned |
| g_i | input | PIX_W | Green channel, unsigned |
| b_i | input | PIX_W | Blue channel, unsigned |
| valid_o | output | 1 | Output pixel qualifier |
| sof_o | output | 1 | Frame start marker, aligned with output |
| eol_o | output | 1 | Line end marker, aligned with output |
| y_o | output | PIX_W | Luminance of the output pixel |
| skin_o | output | 1 | Skin flag of the output pixel |

## Verification
The bench builds the block with its default parameters: 8-bit channels, a U window of 10 to 74, a V floor of −40 and a V ceiling of 11. With 8-bit channels every window edge is reachable by choosing green as a base and moving red or blue one code across each limit, so both sides of all four bounds are driven. The full-scale channel values reach the extremes of the luminance sum and the most negative chroma differences. Streams with gaps show the marker alignment and the hold behaviour.

// File: rtl/skin_pkg.sv
package skin_pkg;
  typedef struct packed {
    logic valid;
    logic sof;
    logic eol;
  } side_t;

  localparam side_t SIDE_IDLE = '{valid: 1'b0, sof: 1'b0, eol: 1'b0};
endpackage

// File: rtl/skin_cspace.sv
module skin_cspace #(
  parameter int PIX_W = 8,
  localparam int SUM_W = PIX_W + 2,
  localparam int CW    = PIX_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [PIX_W-1:0]     r_i,
  input  logic [PIX_W-1:0]     g_i,
  input  logic [PIX_W-1:0]     b_i,
  output logic [PIX_W-1:0]     y_o,
  output logic signed [CW-1:0] u_o,
  output logic signed [CW-1:0] v_o
);
  logic [SUM_W-1:0]     sum;
  logic signed [CW-1:0] u_d, v_d;

  // green weighted by two via a left shift
  assign sum = {2'b00, r_i} + {1'b0, g_i, 1'b0} + {2'b00, b_i};
  assign u_d = $signed({1'b0, r_i}) - $signed({1'b0, g_i});
  assign v_d = $signed({1'b0, b_i}) - $signed({1'b0, g_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o <= '0;
      u_o <= '0;
      v_o <= '0;
    end else if (en_i) begin
      y_o <= sum[SUM_W-1:2];
      u_o <= u_d;
      v_o <= v_d;
    end
  end
endmodule

// File: rtl/skin_window.sv
module skin_window #(
  parameter int PIX_W = 8,
  parameter int U_LO  = 10,
  parameter int U_HI  = 74,
  parameter int V_LO  = -40,
  parameter int V_HI  = 11,
  localparam int CW   = PIX_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [PIX_W-1:0]     y_i,
  input  logic signed [CW-1:0] u_i,
  input  logic signed [CW-1:0] v_i,
  output logic [PIX_W-1:0]     y_o,
  output logic                 skin_o
);
  localparam logic signed [CW-1:0] U_LO_W = CW'(U_LO);
  localparam logic signed [CW-1:0] U_HI_W = CW'(U_HI);
  localparam logic signed [CW-1:0] V_LO_W = CW'(V_LO);
  localparam logic signed [CW-1:0] V_HI_W = CW'(V_HI);

  logic u_ok, v_ok;

  assign u_ok = (u_i > U_LO_W) && (u_i < U_HI_W);
  assign v_ok = (v_i > V_LO_W) && (v_i < V_HI_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o    <= '0;
      skin_o <= 1'b0;
    end else if (en_i) begin
      y_o    <= y_i;
      skin_o <= u_ok && v_ok;
    end
  end

  // R7: a bubble leaves the result registers untouched
  a_r7_hold_in_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(y_o) && $stable(skin_o)));
endmodule

// File: rtl/skin_side_pipe.sv
module skin_side_pipe
  import skin_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  side_t side_i,
  output side_t tap_o [DEPTH]
);
  side_t stage_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    side_t nxt;
    if (i == 0) begin : g_head
      assign nxt = side_i;
    end else begin : g_body
      assign nxt = stage_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= SIDE_IDLE;
      else         stage_q[i] <= nxt;
    end
    assign tap_o[i] = stage_q[i];
  end
endmodule

// File: rtl/skin_classifier.sv
module skin_classifier
  import skin_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int U_LO  = 10,
  parameter int U_HI  = 74,
  parameter int V_LO  = -40,
  parameter int V_HI  = 11,
  localparam int CW   = PIX_W + 1,
  localparam int SUM_W = PIX_W + 2,
  localparam int LAT  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eol_i,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  output logic             valid_o,
  output logic             sof_o,
  output logic             eol_o,
  output logic [PIX_W-1:0] y_o,
  output logic             skin_o
);
  side_t                side_in;
  side_t                tap [LAT];
  logic [PIX_W-1:0]     cs_y;
  logic signed [CW-1:0] cs_u, cs_v;

  // markers travel only with a valid pixel
  assign side_in = '{valid: valid_i, sof: sof_i & valid_i, eol: eol_i & valid_i};

  skin_side_pipe #(.DEPTH(LAT)) u_side (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .side_i(side_in),
    .tap_o (tap)
  );

  skin_cspace #(.PIX_W(PIX_W)) u_cspace (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .r_i   (r_i),
    .g_i   (g_i),
    .b_i   (b_i),
    .y_o   (cs_y),
    .u_o   (cs_u),
    .v_o   (cs_v)
  );

  skin_window #(
    .PIX_W(PIX_W), .U_LO(U_LO), .U_HI(U_HI), .V_LO(V_LO), .V_HI(V_HI)
  ) u_window (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tap[0].valid),
    .y_i   (cs_y),
    .u_i   (cs_u),
    .v_i   (cs_v),
    .y_o   (y_o),
    .skin_o(skin_o)
  );

  assign valid_o = tap[LAT-1].valid;
  assign sof_o   = tap[LAT-1].sof;
  assign eol_o   = tap[LAT-1].eol;

  // ---- port-level checks across the two-stage pipeline ----
  localparam logic signed [CW-1:0] U_LO_C = CW'(U_LO);
  localparam logic signed [CW-1:0] U_HI_C = CW'(U_HI);
  localparam logic signed [CW-1:0] V_LO_C = CW'(V_LO);
  localparam logic signed [CW-1:0] V_HI_C = CW'(V_HI);

  logic [1:0]           warm_q;
  logic [SUM_W-1:0]     chk_sum;
  logic signed [CW-1:0] chk_u, chk_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  assign chk_sum = SUM_W'(r_i) + SUM_W'(g_i) + SUM_W'(g_i) + SUM_W'(b_i);
  assign chk_u   = CW'(r_i) - CW'(g_i);
  assign chk_v   = CW'(b_i) - CW'(g_i);

  a_r6_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  a_r1_luma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && valid_o) |-> (y_o == $past(chk_sum[SUM_W-1:2], 2)));

  a_r2_u_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && valid_o && skin_o) |->
      ($past(chk_u, 2) > U_LO_C && $past(chk_u, 2) < U_HI_C));

  a_r3_v_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && valid_o && skin_o) |-> ($past(chk_v, 2) > V_LO_C));

  a_r4_v_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && valid_o && skin_o) |-> ($past(chk_v, 2) < V_HI_C));

  // R6: markers never leave without a pixel
  a_r6_marker_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o || eol_o) |-> valid_o);
endmodule

// File: tb/skin_classifier_tb.sv
`timescale 1ns/1ps
module skin_classifier_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0, sof_i = 1'b0, eol_i = 1'b0;
  logic [7:0] r_i = '0, g_i = '0, b_i = '0;
  logic       valid_o, sof_o, eol_o, skin_o;
  logic [7:0] y_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  skin_classifier u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sof_i(sof_i), .eol_i(eol_i),
    .r_i(r_i), .g_i(g_i), .b_i(b_i), .valid_o(valid_o), .sof_o(sof_o),
    .eol_o(eol_o), .y_o(y_o), .skin_o(skin_o)
  );

  function automatic int exp_y(int r, int g, int b);
    return (r + 2 * g + b) / 4;
  endfunction

  function automatic bit exp_skin(int r, int g, int b);
    int u, v;
    u = r - g;
    v = b - g;
    return (u > 10) && (u < 74) && (v > -40) && (v < 11);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(bit v, bit s, bit e, int r, int g, int b);
    valid_i = v; sof_i = s; eol_i = e;
    r_i = 8'(r); g_i = 8'(g); b_i = 8'(b);
  endtask

  // one isolated pixel: drive, idle, sample two negedges later
  task automatic one_pixel(int r, int g, int b, string req);
    @(negedge clk) drive(1, 0, 0, r, g, b);
    @(negedge clk) drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check(valid_o == 1'b1, req, valid_o, 1);
    check(y_o == 8'(exp_y(r, g, b)), req, y_o, exp_y(r, g, b));
    check(skin_o == exp_skin(r, g, b), req, skin_o, exp_skin(r, g, b));
  endtask

  task automatic test_reset();
    check(valid_o == 0 && sof_o == 0 && eol_o == 0, "R8 markers", {valid_o, sof_o, eol_o}, 0);
    check(y_o == 0 && skin_o == 0, "R8 data", {y_o, skin_o}, 0);
  endtask

  task automatic test_luma();
    one_pixel(0, 0, 0, "R1 zero");
    one_pixel(255, 255, 255, "R1 full scale");
    one_pixel(1, 2, 3, "R1 mixed");
    one_pixel(200, 17, 99, "R1 uneven");
  endtask

  task automatic test_u_window();
    one_pixel(110, 100, 90, "R2 U=10");
    one_pixel(111, 100, 90, "R2 U=11");
    one_pixel(173, 100, 90, "R2 U=73");
    one_pixel(174, 100, 90, "R2 U=74");
  endtask

  task automatic test_v_floor();
    one_pixel(140, 100, 60, "R3 V=-40");
    one_pixel(140, 100, 61, "R3 V=-39");
  endtask

  task automatic test_v_ceiling();
    one_pixel(140, 100, 110, "R4 V=10");
    one_pixel(140, 100, 111, "R4 V=11");
  endtask

  task automatic test_signed();
    one_pixel(0, 255, 250, "R5 U=-255");
    one_pixel(40, 60, 0, "R5 U=-20 V=-60");
    one_pixel(255, 0, 0, "R5 U=255");
    one_pixel(60, 0, 0, "R5 V=0 U=60");
  endtask

  // back-to-back stream with framing markers
  task automatic test_stream();
    int rr[6] = '{140, 111, 10, 173, 255, 130};
    int gg[6] = '{100, 100, 50, 100, 255, 100};
    int bb[6] = '{90, 99, 20, 110, 0, 70};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int k = i - 2;
        check(valid_o == 1'b1, "R6 stream valid", valid_o, 1);
        check(sof_o == (k == 0), "R6 sof align", sof_o, k == 0);
        check(eol_o == (k == 5), "R6 eol align", eol_o, k == 5);
        check(y_o == 8'(exp_y(rr[k], gg[k], bb[k])), "R6 stream y", y_o, exp_y(rr[k], gg[k], bb[k]));
        check(skin_o == exp_skin(rr[k], gg[k], bb[k]), "R6 stream skin", skin_o,
              exp_skin(rr[k], gg[k], bb[k]));
      end
      if (i < 6) drive(1, i == 0, i == 5, rr[i], gg[i], bb[i]);
      else       drive(0, 0, 0, 0, 0, 0);
    end
    @(negedge clk);
    check(valid_o == 1'b0, "R6 stream drained", valid_o, 0);
  endtask

  // gap between pixels: valid drops, results hold
  task automatic test_bubble();
    @(negedge clk) drive(1, 0, 0, 140, 100, 90);
    @(negedge clk) drive(0, 1, 1, 0, 255, 255);
    @(negedge clk) drive(0, 0, 0, 3, 200, 7);
    check(valid_o == 1'b1 && skin_o == 1'b1, "R7 first pixel", {valid_o, skin_o}, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(valid_o == 1'b0, "R7 valid low", valid_o, 0);
      check(sof_o == 1'b0 && eol_o == 1'b0, "R7 markers low", {sof_o, eol_o}, 0);
      check(y_o == 8'(exp_y(140, 100, 90)), "R7 y hold", y_o, exp_y(140, 100, 90));
      check(skin_o == 1'b1, "R7 skin hold", skin_o, 1);
    end
    drive(1, 0, 0, 20, 100, 100);
    @(negedge clk) drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check(valid_o == 1'b1 && skin_o == 1'b0, "R7 after gap", {valid_o, skin_o}, 2);
    check(y_o == 8'(exp_y(20, 100, 100)), "R7 after gap y", y_o, exp_y(20, 100, 100));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    @(negedge clk) rst_n = 1'b1;
    test_luma();
    test_u_window();
    test_v_floor();
    test_v_ceiling();
    test_signed();
    test_stream();
    test_bubble();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule